// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects a wide set of level-sensitive interrupt sources, arranged as equal groups of eight, and reduces each group to one combined request line. Every source is first brought into the block clock domain through a two-stage synchroniser. After that, its level is qualified by a per-source enable bit. A group's line is asserted while any enabled source in that group is high. The block does no latching, so a request clears when its source drops or when its enable is cleared.

Software reaches the block through a plain 32-bit register port. Reads return their data one cycle after the request. Four groups share each 32-bit register, one byte lane per group. Each block of four groups has a 16-byte window with four registers: an enable set register and an enable clear register, both write-one-to-change, plus raw level and masked level views. One summary word carries a pending bit per group, so a handler can find the active groups with a single read.

Top module: `irq_combiner`

## Requirements
- R1: A change of a source input shows in the status registers after two clock edges, and in the group's combined output after three edges.
- R2: Window n (0 to 7) starts at byte address 16·n. Its word offsets are 0 for enable set, 4 for enable clear, 8 for raw level and 12 for masked level. Source b of group g is bit (g mod 4)·8 + b of window g/4, which is also input bit 8·g + b.
- R3: A write to an enable set register turns on the enable of each bit written as 1. Bits written as 0 keep their enable.
- R4: A write to an enable clear register turns off the enable of each bit written as 1. Bits written as 0 keep their enable.
- R5: The raw level register returns the synchronised level of every source, whatever its enable.
- R6: The masked level register returns the raw level ANDed with the enable mask.
- R7: The summary word at address 0x100 has bit g set when any masked bit of group g is set. Combined output g follows that bit one cycle later.
- R8: A read of either the enable set or the enable clear register returns the current enable mask of its window.
- R9: Reset clears all enables, all combined outputs, the synchroniser stages and the read data.
- R10: Writes to the raw level, masked level, summary or unmapped addresses leave every enable unchanged.
- R11: A read of an unmapped address, including one that is not word aligned, returns zero.
- R12: rd_valid is high in the cycle after each read request. When a read and a write reach the same register in one cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 256 | Asynchronous source levels, bit 8·g+b is source b of group g |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | 9 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rd_valid | output | 1 | rdata is updated for the read of the previous cycle |
| grp_irq_o | output | 32 | Registered combined request per group |

## Verification
Two things can fall on the same clock edge: the synchronised rise of a source, and a software write that changes that source's enable. The bench releases a source, then times an enable clear so that it lands on the same edge where the level leaves the synchroniser. The group line must then stay low on every following cycle. In a second run, an enable set on that same edge must raise the line exactly one cycle later. A read and a write to the same enable register in one cycle are also issued together, and the read is judged to return the mask as it stood before the write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register field inside a window, taken from address bits [3:2]
  typedef enum logic [1:0] {
    FLD_EN_SET = 2'd0,
    FLD_EN_CLR = 2'd1,
    FLD_RAW    = 2'd2,
    FLD_MASKED = 2'd3
  } reg_fld_e;

  localparam int WIN_STRIDE_LOG2 = 4;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int WIDTH  = 256,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[s] <= '0;
          else     stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_window.sv
module irqc_window #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_stb,
  input  logic              clr_stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] raw_i,
  output logic [DATA_W-1:0] en_o,
  output logic [DATA_W-1:0] masked_o
);

  logic [DATA_W-1:0] en_q;
  logic [DATA_W-1:0] set_bits;
  logic [DATA_W-1:0] clr_bits;

  assign set_bits = set_stb ? wdata : '0;
  assign clr_bits = clr_stb ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= (en_q | set_bits) & ~clr_bits;
  end

  assign en_o     = en_q;
  assign masked_o = raw_i & en_q;

endmodule

// File: rtl/irqc_regif.sv
module irqc_regif
  import irqc_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 9,
  parameter int NUM_WIN    = 8,
  parameter int NUM_GROUPS = 32,
  parameter int SUM_ADDR   = 'h100
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic                            rd_en,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [NUM_WIN-1:0][DATA_W-1:0]  en_i,
  input  logic [NUM_WIN-1:0][DATA_W-1:0]  raw_i,
  input  logic [NUM_WIN-1:0][DATA_W-1:0]  masked_i,
  input  logic [NUM_GROUPS-1:0]           pend_i,
  output logic [NUM_WIN-1:0]              set_stb_o,
  output logic [NUM_WIN-1:0]              clr_stb_o,
  output logic [DATA_W-1:0]               rdata,
  output logic                            rd_valid
);

  localparam int WIN_IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
  localparam int TOP_LSB   = WIN_STRIDE_LOG2 + WIN_IDX_W;

  logic [WIN_IDX_W-1:0] win_sel;
  logic                 win_hit;
  logic                 sum_hit;
  reg_fld_e             fld;
  logic [DATA_W-1:0]    rd_word;

  assign win_sel = addr[WIN_STRIDE_LOG2 +: WIN_IDX_W];
  assign fld     = reg_fld_e'(addr[3:2]);
  assign win_hit = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:TOP_LSB] == '0);
  assign sum_hit = (addr == ADDR_W'(SUM_ADDR));

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_stb
      assign set_stb_o[w] = wr_en && win_hit && (win_sel == WIN_IDX_W'(w)) && (fld == FLD_EN_SET);
      assign clr_stb_o[w] = wr_en && win_hit && (win_sel == WIN_IDX_W'(w)) && (fld == FLD_EN_CLR);
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (win_hit) begin
      unique case (fld)
        FLD_EN_SET, FLD_EN_CLR: rd_word = en_i[win_sel];
        FLD_RAW:                rd_word = raw_i[win_sel];
        FLD_MASKED:             rd_word = masked_i[win_sel];
        default:                rd_word = '0;
      endcase
    end else if (sum_hit) begin
      rd_word = DATA_W'(pend_i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
  parameter int NUM_GROUPS  = 32,
  parameter int GRP_SIZE    = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 9,
  parameter int SYNC_STAGES = 2,
  parameter int SUM_ADDR    = 'h100
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GROUPS*GRP_SIZE-1:0] src_i,
  input  logic                           wr_en,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  output logic                           rd_valid,
  output logic [NUM_GROUPS-1:0]          grp_irq_o
);

  localparam int NUM_SRC     = NUM_GROUPS * GRP_SIZE;
  localparam int GRP_PER_WIN = DATA_W / GRP_SIZE;
  localparam int NUM_WIN     = NUM_GROUPS / GRP_PER_WIN;

  logic [NUM_SRC-1:0]               sync_lvl;
  logic [NUM_WIN-1:0][DATA_W-1:0]   raw_w;
  logic [NUM_WIN-1:0][DATA_W-1:0]   en_all;
  logic [NUM_WIN-1:0][DATA_W-1:0]   masked_w;
  logic [NUM_SRC-1:0]               masked_flat;
  logic [NUM_WIN-1:0]               set_stb;
  logic [NUM_WIN-1:0]               clr_stb;
  logic [NUM_GROUPS-1:0]            grp_pend;

  irqc_sync #(
    .WIDTH  (NUM_SRC),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (src_i),
    .q_o (sync_lvl)
  );

  assign raw_w       = sync_lvl;
  assign masked_flat = masked_w;

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      irqc_window #(
        .DATA_W (DATA_W)
      ) u_win (
        .clk      (clk),
        .rst      (rst),
        .set_stb  (set_stb[w]),
        .clr_stb  (clr_stb[w]),
        .wdata    (wdata),
        .raw_i    (raw_w[w]),
        .en_o     (en_all[w]),
        .masked_o (masked_w[w])
      );
    end

    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_pend[g] = |masked_flat[g*GRP_SIZE +: GRP_SIZE];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) grp_irq_o <= '0;
    else     grp_irq_o <= grp_pend;
  end

  irqc_regif #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_WIN    (NUM_WIN),
    .NUM_GROUPS (NUM_GROUPS),
    .SUM_ADDR   (SUM_ADDR)
  ) u_regif (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .en_i      (en_all),
    .raw_i     (raw_w),
    .masked_i  (masked_w),
    .pend_i    (grp_pend),
    .set_stb_o (set_stb),
    .clr_stb_o (clr_stb),
    .rdata     (rdata),
    .rd_valid  (rd_valid)
  );

endmodule

// File: rtl/irq_combiner_chk.sv
module irq_combiner_chk #(
  parameter int NUM_GROUPS = 32,
  parameter int GRP_SIZE   = 8,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 9,
  parameter int SUM_ADDR   = 'h100
) (
  input logic                                            clk,
  input logic                                            rst,
  input logic                                            wr_en,
  input logic                                            rd_en,
  input logic [ADDR_W-1:0]                               addr,
  input logic [DATA_W-1:0]                               wdata,
  input logic [DATA_W-1:0]                               rdata,
  input logic                                            rd_valid,
  input logic [NUM_GROUPS-1:0]                           grp_irq_o,
  input logic [NUM_GROUPS*GRP_SIZE/DATA_W-1:0][DATA_W-1:0] en_all,
  input logic [NUM_GROUPS*GRP_SIZE-1:0]                  sync_lvl
);

  localparam int NUM_WIN = NUM_GROUPS * GRP_SIZE / DATA_W;
  localparam int NUM_SRC = NUM_GROUPS * GRP_SIZE;

  logic [NUM_SRC-1:0]    en_flat;
  logic [NUM_GROUPS-1:0] exp_pend;
  logic                  mapped;

  assign en_flat = en_all;

  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++)
      exp_pend[g] = |(sync_lvl[g*GRP_SIZE +: GRP_SIZE] & en_flat[g*GRP_SIZE +: GRP_SIZE]);
  end

  assign mapped = ((addr[1:0] == 2'b00) && (int'(addr) < NUM_WIN * 16)) ||
                  (addr == ADDR_W'(SUM_ADDR));

  // R7: combined line tracks the qualified group level one cycle later
  a_r7_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> grp_irq_o == $past(exp_pend));

  // R9: no request right after a reset cycle
  a_r9_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (grp_irq_o == '0) && (en_flat == '0));

  // R11: unmapped reads yield zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> rdata == '0);

  // R12: read data valid follows each request
  a_r12_rd_valid: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  generate
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_chk
      // R3: written ones become enabled
      a_r3_set_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(w*16)) |=>
          ((en_all[w] & $past(wdata)) == $past(wdata)));
      // R4: written ones become disabled
      a_r4_clr_bits: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_W'(w*16 + 4)) |=>
          ((en_all[w] & $past(wdata)) == '0));
      // R10: no enable-register write, no enable change
      a_r10_en_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == ADDR_W'(w*16) || addr == ADDR_W'(w*16 + 4))) |=>
          $stable(en_all[w]));
    end
  endgenerate

endmodule

bind irq_combiner irq_combiner_chk #(
  .NUM_GROUPS (NUM_GROUPS),
  .GRP_SIZE   (GRP_SIZE),
  .DATA_W     (DATA_W),
  .ADDR_W     (ADDR_W),
  .SUM_ADDR   (SUM_ADDR)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .rd_en     (rd_en),
  .addr      (addr),
  .wdata     (wdata),
  .rdata     (rdata),
  .rd_valid  (rd_valid),
  .grp_irq_o (grp_irq_o),
  .en_all    (en_all),
  .sync_lvl  (sync_lvl)
);

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NG = 32;
  localparam int NS = 256;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] src_i = '0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [8:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          rd_valid;
  logic [NG-1:0] grp_irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  logic [NS-1:0] en_model = '0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_combiner u_dut (
    .clk       (clk),
    .rst       (rst),
    .src_i     (src_i),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .rdata     (rdata),
    .rd_valid  (rd_valid),
    .grp_irq_o (grp_irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [NG-1:0] exp_pend();
    logic [NG-1:0] p;
    for (int g = 0; g < NG; g++) p[g] = |(src_i[g*8 +: 8] & en_model[g*8 +: 8]);
    return p;
  endfunction

  function automatic logic [31:0] exp_word(input logic [8:0] a);
    int w;
    if (a == 9'h100) return exp_pend();
    if (a[8:7] != 2'b00 || a[1:0] != 2'b00) return '0;
    w = int'(a[6:4]);
    case (a[3:2])
      2'd0, 2'd1: return en_model[w*32 +: 32];
      2'd2:       return src_i[w*32 +: 32];
      default:    return src_i[w*32 +: 32] & en_model[w*32 +: 32];
    endcase
  endfunction

  function automatic void model_write(input logic [8:0] a, input logic [31:0] d);
    int w;
    if (a[8:7] != 2'b00 || a[1:0] != 2'b00) return;
    w = int'(a[6:4]);
    if (a[3:2] == 2'd0) en_model[w*32 +: 32] = en_model[w*32 +: 32] | d;
    if (a[3:2] == 2'd1) en_model[w*32 +: 32] = en_model[w*32 +: 32] & ~d;
  endfunction

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input logic [8:0] a, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = exp_word(a); it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rdwr(input logic [8:0] a, input logic [31:0] d, input string tag);
    rd_item_t it;
    @(negedge clk);
    it.exp = exp_word(a); it.tag = tag;
    sb_q.push_back(it);
    rd_en = 1'b1; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    model_write(a, d);
  endtask

  // Monitor: compare each returned read against the scoreboard queue
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R12 unexpected read data actual=%h expected=none", rdata);
      end else begin
        rd_item_t it;
        it = sb_q.pop_front();
        check(it.tag, rdata, it.exp);
      end
    end
  end

  task automatic wait_sync();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 irq after reset", grp_irq_o, '0);
    check("R9 rdata after reset", rdata, '0);
    rst = 1'b0;
    @(negedge clk);
    check("R12 rd_valid idle", {31'd0, rd_valid}, 32'd0);
    rd(9'h000, "R9 enables zero");
    rd(9'h070, "R9 enables zero w7");

    // R3 / R8
    wr(9'h000, 32'h0000_00A5);
    rd(9'h000, "R3 set readback");
    rd(9'h004, "R8 clr view of mask");
    wr(9'h000, 32'h0100_0000);
    rd(9'h000, "R3 set keeps old bits");
    // R4
    wr(9'h004, 32'h0000_0021);
    rd(9'h004, "R4 clear selected bits");
    rd(9'h000, "R8 set view after clear");

    // R5 / R6 / R7 with a pattern over several windows
    src_i[31:0]    = 32'h8105_00FF;
    src_i[127:96]  = 32'h5A00_3C00;
    src_i[255:224] = 32'h8000_0001;
    wait_sync();
    rd(9'h008, "R5 raw w0");
    rd(9'h038, "R5 raw w3 no enables");
    rd(9'h03C, "R6 masked w3 zero");
    rd(9'h00C, "R6 masked w0");
    rd(9'h100, "R7 summary");
    check("R7 irq pattern", grp_irq_o, exp_pend());

    // R2 boundary: group 31 source 7 is bit 31 of window 7
    wr(9'h070, 32'h8000_0000);
    @(negedge clk);
    check("R2 group31 line", {31'd0, grp_irq_o[31]}, 32'd1);
    rd(9'h07C, "R2 masked w7 top bit");
    rd(9'h100, "R7 summary with g31");

    // R1 latency on group 9 source 3 (input 75)
    wr(9'h020, 32'h0000_0800);
    @(negedge clk);
    src_i[75] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 not yet after two edges", {31'd0, grp_irq_o[9]}, 32'd0);
    @(negedge clk);
    check("R1 asserted after three edges", {31'd0, grp_irq_o[9]}, 32'd1);
    src_i[75] = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 still high two edges after drop", {31'd0, grp_irq_o[9]}, 32'd1);
    @(negedge clk);
    check("R1 released after three edges", {31'd0, grp_irq_o[9]}, 32'd0);

    // R10: writes to non-enable addresses change nothing
    wr(9'h008, 32'hFFFF_FFFF);
    wr(9'h00C, 32'hFFFF_FFFF);
    wr(9'h100, 32'hFFFF_FFFF);
    wr(9'h080, 32'hFFFF_FFFF);
    wr(9'h001, 32'hFFFF_FFFF);
    rd(9'h000, "R10 w0 mask kept");
    rd(9'h010, "R10 w1 mask kept");
    rd(9'h030, "R10 w3 mask kept");
    check("R10 irq unchanged", grp_irq_o, exp_pend());

    // R11
    rd(9'h104, "R11 past summary");
    rd(9'h080, "R11 past windows");
    rd(9'h002, "R11 unaligned");

    // R12 read and write on the same register in one cycle
    rdwr(9'h010, 32'h0000_F00F, "R12 read sees pre-write");
    rd(9'h010, "R12 write took effect");

    // Collision: enable clear lands with the synchronised rise (group 20, input 160)
    wr(9'h050, 32'h0000_0001);
    @(negedge clk);
    src_i[160] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 9'h054; wdata = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(9'h054, 32'h0000_0001);
    for (int k = 0; k < 3; k++) begin
      check("R4 clear wins on shared edge", {31'd0, grp_irq_o[20]}, 32'd0);
      @(negedge clk);
    end
    src_i[160] = 1'b0;
    wait_sync();
    // Companion: enable set on the shared edge raises the line next cycle
    src_i[160] = 1'b1;
    @(negedge clk);
    wr_en = 1'b1; addr = 9'h050; wdata = 32'h0000_0001;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(9'h050, 32'h0000_0001);
    check("R3 set on shared edge not yet", {31'd0, grp_irq_o[20]}, 32'd0);
    @(negedge clk);
    check("R3 set on shared edge one cycle", {31'd0, grp_irq_o[20]}, 32'd1);
    rd(9'h100, "R7 summary after collision");

    repeat (4) @(negedge clk);
    check("R12 all reads returned", sb_q.size(), 32'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule